// File: doc/BRIEF.md
# Channel gamma lookup table

This block applies a per-channel gamma curve to an RGB pixel stream. Each pixel is split into its red, green and blue components. Each component addresses the same table, and each takes back its own colour field from the entry it reads. Software loads the table by writing words, one after another, to a single table register on a simple valid/ready register bus. A second register holds the enable bit that switches the pixel path between table lookup and plain pass-through.

The table is built in one of two variants, chosen by a parameter. The indexed variant holds 256 entries of 8 bits per colour, and each write names its target entry in the top byte of the data word. The streaming variant holds 1024 entries of 10 bits per colour. Its writes fill consecutive entries through an internal pointer. A word with its most significant bit set restarts the fill at entry 0.

Pixel results, their valid flag and a sideband field all leave the block exactly one clock after they enter. After reset the table holds an identity ramp.

Top module: `gamma_lut_top`

## Requirements
- R1: With INDEXED=1, a table write (register address 1) stores wdata[23:0] as the entry whose index is wdata[31:24].
- R2: With INDEXED=0, table writes without bit 31 set store wdata[29:0] at the entry addressed by an internal pointer. The pointer is 0 after reset and advances by one after each table write.
- R3: With INDEXED=0, a table write with wdata[31] set stores wdata[29:0] as entry 0, and the next table write goes to entry 1.
- R4: With INDEXED=0, the pointer wraps from entry 1023 back to entry 0.
- R5: Entries and pixels pack red at [3*BITS-1:2*BITS], green at [2*BITS-1:BITS] and blue at [BITS-1:0]. Each output component is the matching field of the entry indexed by that component's input value.
- R6: Bit 0 of register address 0 enables the lookup. While it is clear, output pixels equal input pixels. A pixel that enters in the same cycle as a write to this bit uses the old setting.
- R7: pix_valid_o, pix_user_o and pix_data_o follow their inputs after exactly one clock.
- R8: After reset the enable bit is clear, the output valid, data and sideband are 0, and entry i holds i in all three colour fields, so enabling before any load leaves pixels unchanged.
- R9: A pixel lookup of an entry in the same cycle that the entry is written returns the value it held before the write.
- R10: reg_ready_o is always 1. A word on reg_wdata_i while reg_valid_i is low, or a write to any register address other than 0 or 1, changes neither the table nor the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_valid_i | input | 1 | Register write request |
| reg_ready_o | output | 1 | Register write accepted (always 1) |
| reg_addr_i | input | ADDR_W | Register address: 0 config, 1 table |
| reg_wdata_i | input | 32 | Register write data |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_data_i | input | 3*BITS | Input pixel, red/green/blue packed |
| pix_user_i | input | USER_W | Sideband carried with the pixel |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_data_o | output | 3*BITS | Corrected or bypassed pixel |
| pix_user_o | output | USER_W | Delayed sideband |

## Verification
Every pixel result, together with its valid flag and sideband, is due one clock after the edge that samples the input. The bench drives inputs on the falling edge. Its reference model predicts the outputs at the rising edge from the table and enable state as they stood before that edge's writes, and the checks compare at the next falling edge. Because of this, same-cycle write and read cases (R6, R9) resolve to the old state without any special handling. Table and enable writes take effect from the rising edge that accepts them, so the first pixel that can show a new entry is the one driven on the cycle after the write.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned IDX_LSB     = 24;
  localparam int unsigned MARK_BIT    = 31;
  localparam int unsigned CFG_EN_BIT  = 0;

  function automatic int unsigned bits_of(bit indexed);
    return indexed ? 8 : 10;
  endfunction

  function automatic int unsigned depth_of(bit indexed);
    return 1 << bits_of(indexed);
  endfunction
endpackage

// File: rtl/gamma_wr_ctrl.sv
module gamma_wr_ctrl
  import gamma_lut_pkg::*;
#(
  parameter bit          INDEXED  = 1'b1,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned BITS     = 8,
  parameter int unsigned AW       = 8,
  parameter int unsigned CFG_ADDR = 0,
  parameter int unsigned TBL_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic              gamma_en_o,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [3*BITS-1:0] wentry_o,
  output logic              marker_o
);
  localparam int unsigned ENT_W = 3 * BITS;

  logic cfg_hit, tbl_hit;
  assign cfg_hit  = reg_valid_i && (reg_addr_i == ADDR_W'(CFG_ADDR));
  assign tbl_hit  = reg_valid_i && (reg_addr_i == ADDR_W'(TBL_ADDR));
  assign we_o     = tbl_hit;
  assign wentry_o = reg_wdata_i[ENT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gamma_en_o <= 1'b0;
    else if (cfg_hit) gamma_en_o <= reg_wdata_i[CFG_EN_BIT];
  end

  generate
    if (INDEXED) begin : g_indexed
      assign waddr_o  = reg_wdata_i[IDX_LSB +: AW];
      assign marker_o = 1'b0;
    end else begin : g_stream
      logic [AW-1:0] ptr_q;
      logic          unused_bits;
      assign marker_o    = reg_wdata_i[MARK_BIT];
      assign waddr_o     = marker_o ? '0 : ptr_q;
      assign unused_bits = ^reg_wdata_i[MARK_BIT-1:ENT_W];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      ptr_q <= '0;
        else if (tbl_hit) ptr_q <= waddr_o + AW'(1);  // wraps at 2**AW
      end
    end
  endgenerate
endmodule

// File: rtl/gamma_table.sv
module gamma_table #(
  parameter int unsigned BITS  = 8,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [3*BITS-1:0] wentry_i,
  input  logic [BITS-1:0]   rd_r_i,
  input  logic [BITS-1:0]   rd_g_i,
  input  logic [BITS-1:0]   rd_b_i,
  output logic [BITS-1:0]   lut_r_o,
  output logic [BITS-1:0]   lut_g_o,
  output logic [BITS-1:0]   lut_b_o
);
  localparam int unsigned ENT_W = 3 * BITS;

  logic [ENT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= {3{BITS'(i)}};  // identity ramp
      end
    end else if (we_i) begin
      mem_q[waddr_i] <= wentry_i;
    end
  end

  // registered reads see pre-write contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lut_r_o <= '0;
      lut_g_o <= '0;
      lut_b_o <= '0;
    end else begin
      lut_r_o <= mem_q[rd_r_i][2*BITS +: BITS];
      lut_g_o <= mem_q[rd_g_i][BITS +: BITS];
      lut_b_o <= mem_q[rd_b_i][0 +: BITS];
    end
  end
endmodule

// File: rtl/gamma_out_stage.sv
module gamma_out_stage #(
  parameter int unsigned BITS   = 8,
  parameter int unsigned USER_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [USER_W-1:0] user_i,
  input  logic [3*BITS-1:0] data_i,
  input  logic              en_i,
  input  logic [BITS-1:0]   lut_r_i,
  input  logic [BITS-1:0]   lut_g_i,
  input  logic [BITS-1:0]   lut_b_i,
  output logic              valid_o,
  output logic [USER_W-1:0] user_o,
  output logic [3*BITS-1:0] data_o
);
  logic              en_q;
  logic [3*BITS-1:0] byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      user_o  <= '0;
      byp_q   <= '0;
      en_q    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      user_o  <= user_i;
      byp_q   <= data_i;
      en_q    <= en_i;
    end
  end

  assign data_o = en_q ? {lut_r_i, lut_g_i, lut_b_i} : byp_q;
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_lut_pkg::*;
#(
  parameter bit          INDEXED  = 1'b1,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned USER_W   = 2,
  parameter int unsigned CFG_ADDR = 0,
  parameter int unsigned TBL_ADDR = 1,
  localparam int unsigned BITS    = bits_of(INDEXED),
  localparam int unsigned DEPTH   = depth_of(INDEXED),
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned PIX_W   = 3 * BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  output logic              reg_ready_o,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  input  logic [USER_W-1:0] pix_user_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_data_o,
  output logic [USER_W-1:0] pix_user_o
);
  logic             gamma_en, tbl_we, tbl_marker;
  logic [AW-1:0]    tbl_waddr;
  logic [PIX_W-1:0] tbl_wentry;
  logic [BITS-1:0]  lut_r, lut_g, lut_b;

  assign reg_ready_o = 1'b1;

  gamma_wr_ctrl #(
    .INDEXED(INDEXED), .ADDR_W(ADDR_W), .BITS(BITS), .AW(AW),
    .CFG_ADDR(CFG_ADDR), .TBL_ADDR(TBL_ADDR)
  ) i_wr_ctrl (
    .clk_i, .rst_ni, .reg_valid_i, .reg_addr_i, .reg_wdata_i,
    .gamma_en_o(gamma_en), .we_o(tbl_we), .waddr_o(tbl_waddr),
    .wentry_o(tbl_wentry), .marker_o(tbl_marker)
  );

  gamma_table #(.BITS(BITS), .DEPTH(DEPTH), .AW(AW)) i_table (
    .clk_i, .rst_ni,
    .we_i(tbl_we), .waddr_i(tbl_waddr), .wentry_i(tbl_wentry),
    .rd_r_i(pix_data_i[2*BITS +: BITS]),
    .rd_g_i(pix_data_i[BITS +: BITS]),
    .rd_b_i(pix_data_i[0 +: BITS]),
    .lut_r_o(lut_r), .lut_g_o(lut_g), .lut_b_o(lut_b)
  );

  gamma_out_stage #(.BITS(BITS), .USER_W(USER_W)) i_out (
    .clk_i, .rst_ni,
    .valid_i(pix_valid_i), .user_i(pix_user_i), .data_i(pix_data_i),
    .en_i(gamma_en), .lut_r_i(lut_r), .lut_g_i(lut_g), .lut_b_i(lut_b),
    .valid_o(pix_valid_o), .user_o(pix_user_o), .data_o(pix_data_o)
  );
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter bit          INDEXED = 1'b1,
  parameter int unsigned PIX_W   = 24,
  parameter int unsigned USER_W  = 2,
  parameter int unsigned AW      = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pix_valid_i,
  input logic [PIX_W-1:0]  pix_data_i,
  input logic [USER_W-1:0] pix_user_i,
  input logic              pix_valid_o,
  input logic [PIX_W-1:0]  pix_data_o,
  input logic [USER_W-1:0] pix_user_o,
  input logic              gamma_en,
  input logic              tbl_we,
  input logic              tbl_marker,
  input logic [AW-1:0]     tbl_waddr
);
  logic          armed, prev_we;
  logic [AW-1:0] prev_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed     <= 1'b0;
      prev_we   <= 1'b0;
      prev_addr <= '0;
    end else begin
      armed     <= 1'b1;
      prev_we   <= tbl_we;
      prev_addr <= tbl_waddr;
    end
  end

  p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (pix_valid_o == $past(pix_valid_i)));

  p_user_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (pix_user_o == $past(pix_user_i)));

  p_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(gamma_en)) |-> (pix_data_o == $past(pix_data_i)));

  // covers R2, R3 (marker leaves 0, next goes to 1) and R4 wrap
  p_ptr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!INDEXED && armed && prev_we && tbl_we && !tbl_marker)
      |-> (tbl_waddr == AW'(prev_addr + AW'(1))));
endmodule

bind gamma_lut_top gamma_lut_chk #(
  .INDEXED(INDEXED), .PIX_W(PIX_W), .USER_W(USER_W), .AW(AW)
) i_gamma_lut_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i), .pix_user_i(pix_user_i),
  .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o), .pix_user_o(pix_user_o),
  .gamma_en(gamma_en), .tbl_we(tbl_we), .tbl_marker(tbl_marker),
  .tbl_waddr(tbl_waddr)
);

// File: tb/test_gamma_lut_top.sv
module test_gamma_lut_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_valid = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  user = '0;
  logic        pv_a = 1'b0, pv_b = 1'b0;
  logic [23:0] pd_a = '0;
  logic [29:0] pd_b = '0;

  logic        rdy_a, rdy_b, ov_a, ov_b;
  logic [23:0] od_a;
  logic [29:0] od_b;
  logic [1:0]  ou_a, ou_b;

  int tests = 0, fails = 0;
  string cur_req = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_lut_top #(.INDEXED(1'b1)) i_gamma_lut_top (
    .clk_i(clk), .rst_ni, .reg_valid_i(reg_valid), .reg_ready_o(rdy_a),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .pix_valid_i(pv_a), .pix_data_i(pd_a), .pix_user_i(user),
    .pix_valid_o(ov_a), .pix_data_o(od_a), .pix_user_o(ou_a)
  );

  gamma_lut_top #(.INDEXED(1'b0)) i_gamma_lut_top_stream (
    .clk_i(clk), .rst_ni, .reg_valid_i(reg_valid), .reg_ready_o(rdy_b),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .pix_valid_i(pv_b), .pix_data_i(pd_b), .pix_user_i(user),
    .pix_valid_o(ov_b), .pix_data_o(od_b), .pix_user_o(ou_b)
  );

  // behavioural reference model
  logic [23:0] tab_a [256];
  logic [29:0] tab_b [1024];
  int          ptr_b;
  bit          en_ref;
  logic        ev_a, ev_b;
  logic [23:0] ed_a;
  logic [29:0] ed_b;
  logic [1:0]  eu;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) tab_a[i] = {3{i[7:0]}};
      for (int i = 0; i < 1024; i++) tab_b[i] = {3{i[9:0]}};
      ptr_b = 0; en_ref = 0;
      ev_a = 0; ev_b = 0; ed_a = '0; ed_b = '0; eu = '0;
    end else begin
      ev_a = pv_a; ev_b = pv_b; eu = user;
      ed_a = en_ref ? {tab_a[pd_a[23:16]][23:16], tab_a[pd_a[15:8]][15:8], tab_a[pd_a[7:0]][7:0]} : pd_a;
      ed_b = en_ref ? {tab_b[pd_b[29:20]][29:20], tab_b[pd_b[19:10]][19:10], tab_b[pd_b[9:0]][9:0]} : pd_b;
      if (reg_valid && reg_addr == 4'd0) en_ref = reg_wdata[0];
      if (reg_valid && reg_addr == 4'd1) begin
        tab_a[reg_wdata[31:24]] = reg_wdata[23:0];
        if (reg_wdata[31]) begin
          tab_b[0] = reg_wdata[29:0]; ptr_b = 1;
        end else begin
          tab_b[ptr_b] = reg_wdata[29:0]; ptr_b = (ptr_b + 1) % 1024;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R7", "valid A", 32'(ov_a), 32'(ev_a));
    chk("R7", "valid B", 32'(ov_b), 32'(ev_b));
    chk("R7", "user A", 32'(ou_a), 32'(eu));
    chk("R7", "user B", 32'(ou_b), 32'(eu));
    chk("R10", "ready", 32'({rdy_a, rdy_b}), 32'd3);
    if (ev_a) chk(cur_req, "data A", 32'(od_a), 32'(ed_a));
    if (ev_b) chk(cur_req, "data B", 32'(od_b), 32'(ed_b));
  endtask

  task automatic cyc(bit rv, logic [3:0] ad, logic [31:0] wd,
                     bit va, logic [23:0] da, bit vb, logic [29:0] db);
    reg_valid = rv; reg_addr = ad; reg_wdata = wd;
    pv_a = va; pd_a = da; pv_b = vb; pd_b = db;
    user = 2'($urandom);
    @(negedge clk);
    compare();
  endtask

  task automatic pixels(int n);
    for (int k = 0; k < n; k++)
      cyc(0, 4'd1, $urandom, 1'b1, 24'($urandom), k[0], 30'($urandom));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "reset valid", 32'({ov_a, ov_b}), 32'd0);
    chk("R8", "reset data A", 32'(od_a), 32'd0);
    chk("R8", "reset data B", 32'(od_b), 32'd0);
    chk("R8", "reset user", 32'({ou_a, ou_b}), 32'd0);
    rst_ni = 1'b1;

    cur_req = "R6"; pixels(20);
    // enable in the same cycle as a pixel: pixel still bypasses (R6)
    cyc(1, 4'd0, 32'd1, 1'b1, 24'h123456, 1'b1, 30'h1234_5678);
    cur_req = "R8"; pixels(20);  // identity ramp

    cur_req = "R1";
    for (int i = 0; i < 256; i++)
      cyc(1, 4'd1, {i[7:0], 8'(255 - i), 8'(i * 3), 8'(i ^ 8'h3c)},
          1'b1, 24'($urandom), 1'b0, '0);
    cur_req = "R5"; pixels(30);

    cur_req = "R3";
    cyc(1, 4'd1, 32'h8000_0000 | 32'h0abc_def0, 1'b0, '0, 1'b1, 30'd0);
    cyc(1, 4'd1, 32'h1555_5555, 1'b0, '0, 1'b1, 30'd0);
    cur_req = "R2";
    for (int i = 0; i < 1030; i++)  // passes 1023 and wraps (R4)
      cyc(1, 4'd1, $urandom & 32'h3fff_ffff, 1'b0, '0, 1'b1, 30'($urandom));
    cur_req = "R4"; pixels(40);
    for (int k = 0; k < 8; k++)
      cyc(0, 4'd0, 0, 1'b0, '0, 1'b1, {10'(k), 10'(k + 1), 10'(1023 - k)});

    cur_req = "R3";
    cyc(1, 4'd1, 32'h8000_0000 | 32'h3ff0_0c01, 1'b0, '0, 1'b0, '0);
    cyc(1, 4'd1, 32'h2aa5_5a5a, 1'b0, '0, 1'b0, '0);
    cyc(1, 4'd1, 32'h0123_4567, 1'b0, '0, 1'b0, '0);
    for (int k = 0; k < 6; k++)
      cyc(0, 4'd0, 0, 1'b0, '0, 1'b1, {10'(k % 3), 10'((k + 1) % 3), 10'((k + 2) % 3)});

    // R9: lookup of entry being written sees old value, then new value
    cur_req = "R9";
    cyc(1, 4'd1, 32'h1099_aa55, 1'b1, 24'h101010, 1'b1, 30'd0);
    cyc(0, 4'd1, 0, 1'b1, 24'h101010, 1'b1, 30'd0);
    cyc(1, 4'd1, 32'h8000_0000 | 32'h0000_7fff, 1'b1, 24'h000000, 1'b1, 30'd0);
    cyc(0, 4'd1, 0, 1'b1, 24'h000000, 1'b1, 30'd0);

    // R10: invalid strobe and foreign address are ignored
    cur_req = "R10";
    cyc(0, 4'd1, 32'h22ff_ffff, 1'b0, '0, 1'b0, '0);
    cyc(1, 4'd5, 32'h22ee_eeee, 1'b0, '0, 1'b0, '0);
    cyc(1, 4'd7, 32'h0000_0000, 1'b0, '0, 1'b0, '0);
    cyc(0, 4'd0, 0, 1'b1, 24'h222222, 1'b1, 30'h0010_0401);
    cyc(0, 4'd0, 0, 1'b1, 24'h223344, 1'b1, 30'h0020_0802);
    pixels(10);

    cur_req = "R6";
    cyc(1, 4'd0, 32'd0, 1'b1, 24'h010203, 1'b1, 30'h0000_0003);
    pixels(20);
    summary();
  end
endmodule